// File: doc/BRIEF.md
# Retry Slave Master Guard

This unit sits inside a bus slave that answers slow accesses with a RETRY response. The slave may be used by only one master at a time. The guard holds the ownership rule in hardware. The first time the slave sends RETRY to a master, the guard stores that master's 4-bit tag. Until that master's transfer finally completes, the guard compares the tag of every new transfer attempt against the stored tag.

When the tags differ, the guard carries out one of four configurable actions:
- an ERROR response to the intruding master;
- a one-cycle flag to the arbiter;
- a one-cycle interrupt;
- a one-cycle reset request.

The guard also runs the slave's wait states. While the slave's internal busy line is high, the transfer is stretched. If busy outlasts a programmed limit, the transfer ends with RETRY, so the ready output always returns high within a bounded time.

The ports are plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure. The interaction with the bus follows its own rule: an attempt is taken only in a cycle where `ready` is high.

Top module: `retry_master_guard`

## Requirements
- R1: After reset, `ready` is 1, `resp` is OKAY (00), `irq`, `arb_flag` and `rst_req` are 0, and no tag is held.
- R2: An attempt is taken when `sel` is 1, `xfer_type` is 10 or 11, and `ready` is 1. The cycles after it are its data phase. Each data-phase cycle with `busy` high has `ready` 0 and `resp` OKAY. The first data-phase cycle with `busy` low has `ready` 1 and `resp` OKAY.
- R3: Busy may last at most `wait_limit`+1 data-phase cycles. After that, the transfer ends with RETRY (10): one cycle with `ready` 0, then one cycle with `ready` 1.
- R4: With `guard_en` at 1, a RETRY that ends a waited transfer stores that attempt's tag. A later attempt carrying the stored tag is served normally.
- R5: With a tag stored, an attempt carrying another tag and `action_sel` = 00 is answered with ERROR (01): one cycle with `ready` 0, then one cycle with `ready` 1.
- R6: In the same mismatch case, `action_sel` 01, 10 or 11 answers the intruder with a two-cycle RETRY. In its first cycle, it raises a one-cycle pulse on `arb_flag`, `irq` or `rst_req` respectively.
- R7: An OKAY completion of the stored master's transfer releases the stored tag. An attempt taken in that same completion cycle is already judged as unlocked.
- R8: With `guard_en` at 0, no tag is stored and no attempt is judged. Any attempt taken while `guard_en` is 0 clears a held tag.
- R9: `ready` is never low for more than `wait_limit`+2 consecutive cycles.
- R10: A cycle with `sel` at 0, or with `xfer_type` 00 or 01, is not an attempt. It never triggers an action and leaves `ready` and `resp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_en | input | 1 | Enables tag capture and comparison |
| action_sel | input | 2 | Action on mismatch: 00 ERROR, 01 arbiter flag, 10 interrupt, 11 reset request |
| sel | input | 1 | Slave selected |
| xfer_type | input | 2 | Transfer type; 10 and 11 are real attempts |
| mst_tag | input | 4 | Tag of the master issuing the current address |
| busy | input | 1 | Slave's internal busy indication |
| wait_limit | input | 8 | Largest wait count before a forced RETRY |
| ready | output | 1 | Transfer-done indication |
| resp | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY |
| irq | output | 1 | One-cycle interrupt pulse |
| arb_flag | output | 1 | One-cycle flag to the arbiter |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Two functions can fall in the same cycle: the release of the held tag on the owner's OKAY completion, and the judging of a different master's attempt that is pipelined into that completion cycle. The bench provokes this by issuing the next attempt in the very cycle in which the owner's wait state ends, with a foreign tag and the ERROR action selected. Receiving OKAY, rather than ERROR, shows that the release was applied first. A second same-cycle case is a fresh attempt taken during the second cycle of an ERROR or RETRY response. It is judged against the tag that the timeout has just captured.

// File: rtl/rmg_pkg.sv
package rmg_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    ACT_ERROR = 2'b00,
    ACT_ARB   = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_RESET = 2'b11
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ERR1,
    ST_ERR2,
    ST_RTY1,
    ST_RTY2
  } gstate_e;

endpackage

// File: rtl/rmg_tag_lock.sv
module rmg_tag_lock #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             capture,
  input  logic             release_i,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [TAG_W-1:0] probe_a,
  input  logic [TAG_W-1:0] probe_b,
  output logic             locked,
  output logic             hit_a,
  output logic             hit_b
);
  logic [TAG_W-1:0] held_q;
  logic             lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else if (!enable) begin
      lock_q <= 1'b0;
    end else if (capture) begin
      lock_q <= 1'b1;
      held_q <= tag_in;
    end else if (release_i) begin
      lock_q <= 1'b0;
    end
  end

  assign locked = lock_q;
  assign hit_a  = (probe_a == held_q);
  assign hit_b  = (probe_b == held_q);
endmodule

// File: rtl/rmg_wait_timer.sv
module rmg_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != {W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/rmg_action_dec.sv
module rmg_action_dec #(
  parameter int N_ACT = 4,
  localparam int SEL_W = $clog2(N_ACT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SEL_W-1:0] pick,
  output logic [N_ACT-1:1] pulse
);
  for (genvar k = 1; k < N_ACT; k++) begin : g_slot
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= fire && (pick == SEL_W'(k));
    end
    assign pulse[k] = q;
  end
endmodule

// File: rtl/retry_master_guard.sv
module retry_master_guard
  import rmg_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_en,
  input  logic [1:0]        action_sel,
  input  logic              sel,
  input  logic [1:0]        xfer_type,
  input  logic [TAG_W-1:0]  mst_tag,
  input  logic              busy,
  input  logic [WAIT_W-1:0] wait_limit,
  output logic              ready,
  output logic [1:0]        resp,
  output logic              irq,
  output logic              arb_flag,
  output logic              rst_req
);
  localparam int N_ACT = 4;

  gstate_e          state_q, state_d;
  logic [TAG_W-1:0] cur_tag_q;
  logic             ready_c, accept, done_ok, release_c, violate, timeout;
  logic             capture, fire, locked, hit_cur, hit_new, expired;
  rsp_e             resp_c;
  gstate_e          start_next;
  logic [N_ACT-1:1] pulses;

  always_comb begin
    case (state_q)
      ST_WAIT:          ready_c = !busy;
      ST_ERR1, ST_RTY1: ready_c = 1'b0;
      default:          ready_c = 1'b1;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_ERR1, ST_ERR2: resp_c = RSP_ERROR;
      ST_RTY1, ST_RTY2: resp_c = RSP_RETRY;
      default:          resp_c = RSP_OKAY;
    endcase
  end

  assign accept    = ready_c && sel && (xfer_type == 2'b10 || xfer_type == 2'b11);
  assign done_ok   = (state_q == ST_WAIT) && !busy;
  assign release_c = done_ok && locked && hit_cur;
  assign violate   = accept && guard_en && locked && !release_c && !hit_new;
  assign timeout   = (state_q == ST_WAIT) && busy && expired;
  assign capture   = timeout && guard_en && !locked;
  assign fire      = violate && (action_sel != ACT_ERROR);

  always_comb begin
    if (!accept)      start_next = ST_IDLE;
    else if (!violate) start_next = ST_WAIT;
    else if (action_sel == ACT_ERROR) start_next = ST_ERR1;
    else              start_next = ST_RTY1;
  end

  always_comb begin
    case (state_q)
      ST_WAIT: state_d = busy ? (timeout ? ST_RTY1 : ST_WAIT) : start_next;
      ST_ERR1: state_d = ST_ERR2;
      ST_RTY1: state_d = ST_RTY2;
      default: state_d = start_next;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) cur_tag_q <= mst_tag;
    end
  end

  rmg_tag_lock #(.TAG_W(TAG_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (guard_en),
    .capture  (capture),
    .release_i(release_c),
    .tag_in   (cur_tag_q),
    .probe_a  (cur_tag_q),
    .probe_b  (mst_tag),
    .locked   (locked),
    .hit_a    (hit_cur),
    .hit_b    (hit_new)
  );

  rmg_wait_timer #(.W(WAIT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .run    ((state_q == ST_WAIT) && busy),
    .limit  (wait_limit),
    .expired(expired)
  );

  rmg_action_dec #(.N_ACT(N_ACT)) u_act (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .pick (action_sel),
    .pulse(pulses)
  );

  assign ready    = ready_c;
  assign resp     = resp_c;
  assign arb_flag = pulses[1];
  assign irq      = pulses[2];
  assign rst_req  = pulses[3];
endmodule

// File: rtl/retry_master_guard_chk.sv
module retry_master_guard_chk #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              guard_en,
  input logic              busy,
  input logic [WAIT_W-1:0] wait_limit,
  input logic              ready,
  input logic [1:0]        resp,
  input logic              irq,
  input logic              arb_flag,
  input logic              rst_req
);
  logic [WAIT_W+1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                  low_run <= '0;
    else if (ready)              low_run <= '0;
    else if (low_run != '1)      low_run <= low_run + 1'b1;
  end

  // R9
  ready_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (low_run <= {2'b00, wait_limit} + 1));

  // R2
  okay_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && resp == 2'b00) |-> busy);

  // R5
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && resp == 2'b01) |=> (ready && resp == 2'b01));

  // R3
  rty_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && resp == 2'b10) |=> (ready && resp == 2'b10));

  // R6
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, arb_flag, rst_req}));

  // R6
  flag_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || arb_flag || rst_req) |-> (!ready && resp == 2'b10));

  // R6
  flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || arb_flag || rst_req) |=> !(irq || arb_flag || rst_req));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || arb_flag || rst_req) |-> $past(guard_en));
endmodule

bind retry_master_guard retry_master_guard_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .guard_en  (guard_en),
  .busy      (busy),
  .wait_limit(wait_limit),
  .ready     (ready),
  .resp      (resp),
  .irq       (irq),
  .arb_flag  (arb_flag),
  .rst_req   (rst_req)
);

// File: tb/retry_master_guard_bench.sv
`timescale 1ns/1ps
module retry_master_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       guard_en = 1'b0;
  logic [1:0] action_sel = 2'b00;
  logic       sel = 1'b0;
  logic [1:0] xfer_type = 2'b00;
  logic [3:0] mst_tag = 4'd0;
  logic       busy = 1'b0;
  logic [7:0] wait_limit = 8'd3;
  logic       ready;
  logic [1:0] resp;
  logic       irq, arb_flag, rst_req;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  retry_master_guard u_retry_master_guard (
    .clk(clk), .rst_n(rst_n), .guard_en(guard_en), .action_sel(action_sel),
    .sel(sel), .xfer_type(xfer_type), .mst_tag(mst_tag), .busy(busy),
    .wait_limit(wait_limit), .ready(ready), .resp(resp), .irq(irq),
    .arb_flag(arb_flag), .rst_req(rst_req)
  );

  // {en, act[1:0], tag[3:0], nbusy[3:0], exp_resp[1:0], exp_flags{rst,irq,arb}, exp_low[3:0]}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 2'd0, 4'd2, 4'd0,  2'b00, 3'b000, 4'd0}, // R2 free slave
    {1'b1, 2'd0, 4'd5, 4'd10, 2'b10, 3'b000, 4'd5}, // R3 R4 timeout captures 5
    {1'b1, 2'd0, 4'd3, 4'd0,  2'b01, 3'b000, 4'd1}, // R5 intruder gets ERROR
    {1'b1, 2'd1, 4'd3, 4'd0,  2'b10, 3'b001, 4'd1}, // R6 arbiter flag
    {1'b1, 2'd2, 4'd3, 4'd0,  2'b10, 3'b010, 4'd1}, // R6 interrupt
    {1'b1, 2'd3, 4'd3, 4'd0,  2'b10, 3'b100, 4'd1}, // R6 reset request
    {1'b1, 2'd0, 4'd5, 4'd2,  2'b00, 3'b000, 4'd2}, // R4 R7 owner completes
    {1'b1, 2'd0, 4'd3, 4'd0,  2'b00, 3'b000, 4'd0}, // R7 same-cycle pipelined
    {1'b0, 2'd0, 4'd7, 4'd10, 2'b10, 3'b000, 4'd5}, // R8 retry without capture
    {1'b1, 2'd0, 4'd8, 4'd0,  2'b00, 3'b000, 4'd0}, // R8 nothing was held
    {1'b1, 2'd0, 4'd9, 4'd5,  2'b10, 3'b000, 4'd5}, // R4 capture 9
    {1'b0, 2'd1, 4'd1, 4'd0,  2'b00, 3'b000, 4'd0}, // R8 bypass clears hold
    {1'b1, 2'd1, 4'd1, 4'd0,  2'b00, 3'b000, 4'd0}  // R8 hold is gone
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit en, input logic [1:0] act, input logic [3:0] tag,
                         input int nbusy, output logic [1:0] r, output logic [2:0] f,
                         output int low);
    int k;
    guard_en = en; action_sel = act; mst_tag = tag;
    sel = 1'b1; xfer_type = 2'b10; busy = 1'b0;
    @(negedge clk);
    sel = 1'b0; xfer_type = 2'b00;
    f = 3'b000; low = 0; k = 0; r = 2'b11;
    busy = (nbusy > 0);
    while (k < 40) begin
      #1;
      f |= {rst_req, irq, arb_flag};
      if (ready) begin
        r = resp;
        break;
      end
      low++;
      @(negedge clk);
      k++;
      busy = (k < nbusy);
    end
  endtask

  task automatic expect_txn(input bit en, input logic [1:0] act, input logic [3:0] tag,
                            input int nbusy, input logic [1:0] er, input logic [2:0] ef,
                            input int el, input string req);
    logic [1:0] r; logic [2:0] f; int low;
    run_txn(en, act, tag, nbusy, r, f, low);
    chk(r == er, req, r, er);
    chk(f == ef, req, f, ef);
    chk(low == el, "R9", low, el);
  endtask

  task automatic idle_cycles(input int n);
    sel = 1'b0; xfer_type = 2'b00; busy = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ready == 1'b1, "R1", ready, 1);
    chk(resp == 2'b00, "R1", resp, 0);
    chk({rst_req, irq, arb_flag} == 3'b000, "R1", {rst_req, irq, arb_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v; logic [1:0] r; logic [2:0] f; int low; string req;
      v = VEC[i];
      run_txn(v[19], v[18:17], v[16:13], int'(v[12:9]), r, f, low);
      if (v[6:4] != 3'b000)      req = "R6";
      else if (v[8:7] == 2'b01)  req = "R5";
      else if (v[8:7] == 2'b10)  req = "R3";
      else                       req = "R2";
      chk(r == v[8:7], req, r, v[8:7]);
      chk(f == v[6:4], req, f, v[6:4]);
      chk(low == int'(v[3:0]), "R9", low, v[3:0]);
    end

    // R10: non-attempt cycles while tag 4 is held
    idle_cycles(2);
    expect_txn(1'b1, 2'd1, 4'd4, 10, 2'b10, 3'b000, 5, "R4");
    idle_cycles(1);
    guard_en = 1'b1; action_sel = 2'd1; mst_tag = 4'd6;
    sel = 1'b1; xfer_type = 2'b01;
    @(negedge clk); #1;
    chk(ready && resp == 2'b00 && !arb_flag, "R10", {ready, resp, arb_flag}, 4'b1000);
    xfer_type = 2'b00;
    @(negedge clk); #1;
    chk(ready && resp == 2'b00 && !arb_flag, "R10", {ready, resp, arb_flag}, 4'b1000);
    sel = 1'b0; xfer_type = 2'b10;
    @(negedge clk); #1;
    chk(ready && resp == 2'b00 && !arb_flag, "R10", {ready, resp, arb_flag}, 4'b1000);
    idle_cycles(1);
    expect_txn(1'b1, 2'd1, 4'd6, 0, 2'b10, 3'b001, 1, "R4");
    expect_txn(1'b1, 2'd1, 4'd4, 0, 2'b00, 3'b000, 0, "R7");
    expect_txn(1'b1, 2'd1, 4'd6, 0, 2'b00, 3'b000, 0, "R7");

    // R3 with a zero limit, then R8 bypass of a held tag
    idle_cycles(1);
    wait_limit = 8'd0;
    expect_txn(1'b1, 2'd0, 4'd2, 3, 2'b10, 3'b000, 2, "R3");
    expect_txn(1'b0, 2'd0, 4'd9, 0, 2'b00, 3'b000, 0, "R8");
    expect_txn(1'b1, 2'd0, 4'd9, 0, 2'b00, 3'b000, 0, "R8");
    idle_cycles(1);
    wait_limit = 8'd3;

    // R1 reset while a tag is held clears it
    expect_txn(1'b1, 2'd0, 4'd4, 10, 2'b10, 3'b000, 5, "R4");
    idle_cycles(1);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk(ready == 1'b1 && resp == 2'b00, "R1", {ready, resp}, 4);
    rst_n = 1'b1;
    idle_cycles(1);
    expect_txn(1'b1, 2'd2, 4'd6, 0, 2'b00, 3'b000, 0, "R1");

    idle_cycles(2);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule